// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This register block lets two agents pass short messages and signal each other. Each side owns four 16-bit outgoing mailboxes that only it may write. The other side may read them. When a side writes the upper byte of one of its mailboxes, an interrupt source is raised on the other side. That source stays pending until the receiving side reads the upper byte of the same mailbox through its peer window. The acknowledging read leaves the message intact.

Each side has its own synchronous register port: a select, a 6-bit address, a write strobe, two byte enables, write data and read data. A cycle with the select high and the write strobe low is a read. Read data is combinational on the addressed location. Each side also has a control word with three fields. The mask field can be written. The cause field records only events that were unmasked when they arrived. The status field records every event, masked or not. The side's active-low interrupt output is low while any cause bit is pending.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1 and no source is pending, so the control word reads 0x0FFF. Every mailbox reads 0x0000 and both interrupt outputs are high.
- R2: Address 6'b1000xx selects own mailbox xx. Byte enable bit 0 writes bits 7:0 and bit 1 writes bits 15:8. A read at the same address returns the stored word, and reading own mailboxes never changes the other side's pending sources.
- R3: Address 6'b1001xx reads mailbox xx of the other side. Writes to this window change nothing.
- R4: A write to own mailbox k with byte enable bit 1 set raises pending source k on the other side in the next cycle. A write with only byte enable bit 0 raises nothing.
- R5: A raised source k sets cause bit k only if mask bit k is 0 at the time it arrives. The status bit is set whatever the mask. The interrupt output is low exactly while any cause bit is set.
- R6: A read of peer mailbox k with byte enable bit 1 set clears cause bit k and status bit k of the reader, with effect from the next cycle, and leaves the mailbox data unchanged. A read with only byte enable bit 0 clears nothing.
- R7: The control word at 6'b101000 reads as {4'b0000, ~status[3:0], ~cause[3:0], mask[3:0]}, so a 0 in the cause or status field means pending. A write with byte enable bit 0 set loads all four mask bits from write data bits 3:0. The cause and status fields ignore writes.
- R8: Writes to all other addresses, and any cycle with the select low, change no state. Reads from those addresses return 0x0000.
- R9: If a raise and an acknowledge of the same source happen in the same cycle, the source stays pending.
- R10: Changing the mask never alters cause bits that are already set or already clear. Unmasking a source that has a pending status bit does not set its cause bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_i | input | 1 | Side A register access select |
| a_addr_i | input | 6 | Side A register address |
| a_wr_i | input | 1 | Side A write strobe (low = read) |
| a_be_i | input | 2 | Side A byte enables |
| a_wdata_i | input | 16 | Side A write data |
| a_rdata_o | output | 16 | Side A read data |
| a_irq_no | output | 1 | Side A interrupt, active low |
| b_sel_i | input | 1 | Side B register access select |
| b_addr_i | input | 6 | Side B register address |
| b_wr_i | input | 1 | Side B write strobe (low = read) |
| b_be_i | input | 2 | Side B byte enables |
| b_wdata_i | input | 16 | Side B write data |
| b_rdata_o | output | 16 | Side B read data |
| b_irq_no | output | 1 | Side B interrupt, active low |

## Verification
Mailbox writes are applied with each byte-enable combination. This separates lane steering from interrupt raising, because a lower-only write must update data without raising a source. Acknowledging reads are applied both as lower-only and as upper-byte reads, and also as own-window readbacks, so that only the one clearing pattern is seen to drop the interrupt. The mask is changed before a raise and again after one, which separates the post-mask cause field from the pre-mask status field. A raise and an acknowledge of the same mailbox in one cycle fix the precedence, and traffic in both directions shows that the two sides are independent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_OWN,
    ACC_PEER,
    ACC_CTRL,
    ACC_RSVD
  } acc_kind_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned N_MBOX = 4,
  localparam int unsigned IDX_W = $clog2(N_MBOX)
) (
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned PG_W = ADDR_W - IDX_W;
  localparam logic [PG_W-1:0] OWN_PG  = {1'b1, {(PG_W-1){1'b0}}};
  localparam logic [PG_W-1:0] PEER_PG = OWN_PG | PG_W'(1);
  localparam logic [PG_W-1:0] CTRL_PG = OWN_PG | PG_W'(2);

  logic [PG_W-1:0] page;
  assign page  = addr_i[ADDR_W-1:IDX_W];
  assign idx_o = addr_i[IDX_W-1:0];

  always_comb begin
    if (!sel_i)                                kind_o = ACC_NONE;
    else if (page == OWN_PG)                   kind_o = ACC_OWN;
    else if (page == PEER_PG)                  kind_o = ACC_PEER;
    else if (page == CTRL_PG && idx_o == '0)   kind_o = ACC_CTRL;
    else                                       kind_o = ACC_RSVD;
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_MBOX = 4,
  localparam int unsigned IDX_W = $clog2(N_MBOX),
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [BE_W-1:0]                be_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_MBOX-1:0][DATA_W-1:0]  mbox_o,
  output logic [N_MBOX-1:0]              hi_wr_o
);
  logic [N_MBOX-1:0][DATA_W-1:0] mbox_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbox_q <= '0;
    end else if (we_i) begin
      for (int l = 0; l < BE_W; l++) begin
        if (be_i[l]) mbox_q[idx_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
      end
    end
  end

  // top lane carries the doorbell
  assign hi_wr_o = (we_i && be_i[BE_W-1]) ? (N_MBOX'(1) << idx_i) : '0;
  assign mbox_o  = mbox_q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mbox_q));
endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
  parameter int unsigned N_MBOX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MBOX-1:0] set_i,
  input  logic [N_MBOX-1:0] ack_i,
  input  logic              mask_we_i,
  input  logic [N_MBOX-1:0] mask_d_i,
  output logic [N_MBOX-1:0] mask_o,
  output logic [N_MBOX-1:0] cause_o,
  output logic [N_MBOX-1:0] status_o,
  output logic              irq_no
);
  logic [N_MBOX-1:0] mask_q, cause_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      cause_q  <= '0;
      status_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_d_i;
      // raise beats acknowledge
      status_q <= (status_q & ~ack_i) | set_i;
      cause_q  <= (cause_q & ~ack_i) | (set_i & ~mask_q);
    end
  end

  assign mask_o   = mask_q;
  assign cause_o  = cause_q;
  assign status_o = status_q;
  assign irq_no   = ~|cause_q;

  for (genvar k = 0; k < N_MBOX; k++) begin : g_chk
    assert_status_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> status_q[k]);
    assert_cause_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] && !mask_q[k] |=> !irq_no);
    assert_masked_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_i[k] && !mask_q[k]) && !ack_i[k] |=> $stable(cause_q[k]));
    assert_ack_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[k] && !set_i[k] |=> !status_q[k] && !cause_q[k]);
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] && ack_i[k] |=> status_q[k]);
  end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_MBOX = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_sel_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_wr_i,
  input  logic [BE_W-1:0]   a_be_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_no,
  input  logic              b_sel_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_wr_i,
  input  logic [BE_W-1:0]   b_be_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_no
);
  localparam int unsigned IDX_W = $clog2(N_MBOX);
  localparam int unsigned PAD_W = DATA_W - 3 * N_MBOX;

  logic                          sel   [2];
  logic                          wr    [2];
  logic [ADDR_W-1:0]             addr  [2];
  logic [BE_W-1:0]               be    [2];
  logic [DATA_W-1:0]             wdata [2];
  logic [DATA_W-1:0]             rdata [2];
  logic                          irq_n [2];
  logic [N_MBOX-1:0][DATA_W-1:0] mbox  [2];
  logic [N_MBOX-1:0]             hi_wr [2];

  assign sel[0] = a_sel_i;   assign sel[1] = b_sel_i;
  assign wr[0] = a_wr_i;     assign wr[1] = b_wr_i;
  assign addr[0] = a_addr_i; assign addr[1] = b_addr_i;
  assign be[0] = a_be_i;     assign be[1] = b_be_i;
  assign wdata[0] = a_wdata_i; assign wdata[1] = b_wdata_i;
  assign a_rdata_o = rdata[0]; assign b_rdata_o = rdata[1];
  assign a_irq_no = irq_n[0];  assign b_irq_no = irq_n[1];

  for (genvar p = 0; p < 2; p++) begin : g_side
    localparam int Q = 1 - p;
    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              own_we, mask_we;
    logic [N_MBOX-1:0] ack, mask, cause, status;

    mbx_decode #(.ADDR_W(ADDR_W), .N_MBOX(N_MBOX)) i_dec (
      .sel_i (sel[p]),
      .addr_i(addr[p]),
      .kind_o(kind),
      .idx_o (idx)
    );

    assign own_we  = (kind == ACC_OWN) && wr[p];
    assign mask_we = (kind == ACC_CTRL) && wr[p] && be[p][0];
    assign ack     = ((kind == ACC_PEER) && !wr[p] && be[p][BE_W-1])
                     ? (N_MBOX'(1) << idx) : '0;

    mbx_store #(.DATA_W(DATA_W), .N_MBOX(N_MBOX)) i_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (own_we),
      .idx_i  (idx),
      .be_i   (be[p]),
      .wdata_i(wdata[p]),
      .mbox_o (mbox[p]),
      .hi_wr_o(hi_wr[p])
    );

    mbx_irq_bank #(.N_MBOX(N_MBOX)) i_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (hi_wr[Q]),
      .ack_i    (ack),
      .mask_we_i(mask_we),
      .mask_d_i (wdata[p][N_MBOX-1:0]),
      .mask_o   (mask),
      .cause_o  (cause),
      .status_o (status),
      .irq_no   (irq_n[p])
    );

    always_comb begin
      unique case (kind)
        ACC_OWN:  rdata[p] = mbox[p][idx];
        ACC_PEER: rdata[p] = mbox[Q][idx];
        ACC_CTRL: rdata[p] = {{PAD_W{1'b0}}, ~status, ~cause, mask};
        default:  rdata[p] = '0;
      endcase
    end

    assert_ack_keeps_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|ack) && !wr[Q] |=> $stable(mbox[Q]));
  end
endmodule

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        a_sel = 0, b_sel = 0, a_wr = 0, b_wr = 0;
  logic [5:0]  a_addr = 0, b_addr = 0;
  logic [1:0]  a_be = 0, b_be = 0;
  logic [15:0] a_wdata = 0, b_wdata = 0;
  logic [15:0] a_rdata, b_rdata;
  logic        a_irq_n, b_irq_n;

  mbx_irq_ctrl i_mbx_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .a_sel_i(a_sel), .a_addr_i(a_addr), .a_wr_i(a_wr), .a_be_i(a_be),
    .a_wdata_i(a_wdata), .a_rdata_o(a_rdata), .a_irq_no(a_irq_n),
    .b_sel_i(b_sel), .b_addr_i(b_addr), .b_wr_i(b_wr), .b_be_i(b_be),
    .b_wdata_i(b_wdata), .b_rdata_o(b_rdata), .b_irq_no(b_irq_n)
  );

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [15:0] mbm [2][4];
  logic [3:0]  mk [2], cs [2], st [2];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int p, input logic [5:0] ad);
    if (ad[5:2] == 4'b1000) return mbm[p][ad[1:0]];
    if (ad[5:2] == 4'b1001) return mbm[1-p][ad[1:0]];
    if (ad == 6'b101000)    return {4'h0, ~st[p], ~cs[p], mk[p]};
    return 16'h0000;
  endfunction

  task automatic drive(input int p, input bit s, input bit w, input logic [5:0] ad,
                       input logic [1:0] bm, input logic [15:0] d);
    if (p == 0) begin a_sel = s; a_wr = w; a_addr = ad; a_be = bm; a_wdata = d; end
    else        begin b_sel = s; b_wr = w; b_addr = ad; b_be = bm; b_wdata = d; end
  endtask

  task automatic model_wr(input int p, input logic [5:0] ad, input logic [1:0] bm,
                          input logic [15:0] d);
    if (ad[5:2] == 4'b1000) begin
      if (bm[0]) mbm[p][ad[1:0]][7:0]  = d[7:0];
      if (bm[1]) begin
        mbm[p][ad[1:0]][15:8] = d[15:8];
        st[1-p][ad[1:0]] = 1'b1;
        if (!mk[1-p][ad[1:0]]) cs[1-p][ad[1:0]] = 1'b1;
      end
    end else if (ad == 6'b101000 && bm[0]) begin
      mk[p] = d[3:0];
    end
  endtask

  task automatic model_ack(input int p, input logic [5:0] ad, input logic [1:0] bm);
    if (ad[5:2] == 4'b1001 && bm[1]) begin
      st[p][ad[1:0]] = 1'b0;
      cs[p][ad[1:0]] = 1'b0;
    end
  endtask

  task automatic chk_irq(input string tag);
    chk({tag, " irqA"}, {15'h0, a_irq_n}, {15'h0, ~|cs[0]});
    chk({tag, " irqB"}, {15'h0, b_irq_n}, {15'h0, ~|cs[1]});
  endtask

  task automatic wr(input int p, input logic [5:0] ad, input logic [1:0] bm,
                    input logic [15:0] d, input string tag);
    @(negedge clk);
    drive(p, 1'b1, 1'b1, ad, bm, d);
    @(posedge clk);
    #1;
    model_wr(p, ad, bm, d);
    drive(p, 1'b0, 1'b0, 6'h0, 2'b00, 16'h0);
    chk_irq(tag);
  endtask

  task automatic rd(input int p, input logic [5:0] ad, input logic [1:0] bm, input string tag);
    logic [15:0] got;
    @(negedge clk);
    drive(p, 1'b1, 1'b0, ad, bm, 16'h0);
    #1;
    got = (p == 0) ? a_rdata : b_rdata;
    chk(tag, got, exp_rd(p, ad));
    @(posedge clk);
    #1;
    model_ack(p, ad, bm);
    drive(p, 1'b0, 1'b0, 6'h0, 2'b00, 16'h0);
    chk_irq(tag);
  endtask

  task automatic t_reset;
    chk_irq("R1 reset");
    rd(0, 6'b101000, 2'b11, "R1 ctrl A");
    rd(1, 6'b101000, 2'b11, "R1 ctrl B");
    chk("R1 ctrl value", exp_rd(0, 6'b101000), 16'h0FFF);
    for (int k = 0; k < 4; k++) rd(0, 6'(6'b100000 + k), 2'b01, "R1 mailbox zero");
  endtask

  task automatic t_byte_lanes;
    wr(0, 6'b100001, 2'b01, 16'h1234, "R2 low lane");
    rd(0, 6'b100001, 2'b11, "R2 low lane readback");
    wr(0, 6'b100001, 2'b10, 16'hAB99, "R2 high lane");
    rd(0, 6'b100001, 2'b11, "R2 merged readback");
    rd(1, 6'b101000, 2'b11, "R2 peer status after own readback");
  endtask

  task automatic t_peer_view;
    rd(1, 6'b100101, 2'b01, "R3 peer read");
    wr(1, 6'b100101, 2'b11, 16'hFFFF, "R3 peer write");
    rd(0, 6'b100001, 2'b11, "R3 data kept after peer write");
    rd(1, 6'b100001, 2'b11, "R3 own box of B untouched");
  endtask

  task automatic t_irq_set;
    wr(1, 6'b101000, 2'b01, 16'h0000, "R7 unmask B");
    wr(0, 6'b100010, 2'b01, 16'h0055, "R4 lower-only no raise");
    rd(1, 6'b101000, 2'b11, "R4 ctrl after lower write");
    wr(0, 6'b100010, 2'b10, 16'h7700, "R4 upper write raises");
    rd(1, 6'b101000, 2'b11, "R5 ctrl after raise");
    rd(0, 6'b100010, 2'b11, "R2 own readback keeps peer irq");
  endtask

  task automatic t_ack;
    rd(1, 6'b100110, 2'b01, "R6 lower read no clear");
    rd(1, 6'b100110, 2'b10, "R6 upper read clears");
    rd(1, 6'b100110, 2'b11, "R6 data unchanged");
    rd(1, 6'b101000, 2'b11, "R6 ctrl after ack");
  endtask

  task automatic t_mask;
    wr(1, 6'b101000, 2'b01, 16'h0008, "R5 mask box3");
    wr(0, 6'b100011, 2'b11, 16'h1111, "R5 masked raise");
    rd(1, 6'b101000, 2'b11, "R5 status only");
    wr(1, 6'b101000, 2'b01, 16'h0000, "R10 unmask pending");
    rd(1, 6'b101000, 2'b11, "R10 cause not set by unmask");
    rd(1, 6'b100111, 2'b10, "R6 ack masked source");
    wr(0, 6'b100000, 2'b10, 16'h2200, "R5 unmasked raise");
    wr(1, 6'b101000, 2'b01, 16'h000F, "R10 mask after raise");
    rd(1, 6'b101000, 2'b11, "R10 cause kept");
    rd(1, 6'b100100, 2'b10, "R6 ack box0");
  endtask

  task automatic t_ctrl_fields;
    wr(0, 6'b101000, 2'b10, 16'hFFF0, "R7 upper-only ctrl write");
    rd(0, 6'b101000, 2'b11, "R7 mask unchanged");
    wr(1, 6'b100010, 2'b10, 16'h3300, "R7 raise on A");
    wr(0, 6'b101000, 2'b11, 16'h0005, "R7 mask write, fields ro");
    rd(0, 6'b101000, 2'b11, "R7 field layout");
    rd(0, 6'b100110, 2'b10, "R6 ack on A");
  endtask

  task automatic t_reserved;
    wr(0, 6'b000011, 2'b11, 16'hFFFF, "R8 reserved low");
    wr(0, 6'b110000, 2'b11, 16'hFFFF, "R8 reserved high");
    wr(0, 6'b101001, 2'b11, 16'hFFFF, "R8 reserved near ctrl");
    wr(0, 6'b101100, 2'b11, 16'hFFFF, "R8 reserved page");
    @(negedge clk);
    drive(0, 1'b0, 1'b1, 6'b100000, 2'b11, 16'hDEAD);
    @(posedge clk);
    #1;
    drive(0, 1'b0, 1'b0, 6'h0, 2'b00, 16'h0);
    chk_irq("R8 select low");
    rd(0, 6'b000011, 2'b11, "R8 reserved read");
    rd(0, 6'b111111, 2'b11, "R8 reserved read top");
    rd(0, 6'b100000, 2'b11, "R8 box0 intact");
    rd(0, 6'b101000, 2'b11, "R8 ctrl intact");
    rd(1, 6'b101000, 2'b11, "R8 peer ctrl intact");
  endtask

  task automatic t_collide;
    logic [15:0] got;
    wr(1, 6'b101000, 2'b01, 16'h0000, "R9 unmask B");
    @(negedge clk);
    drive(0, 1'b1, 1'b1, 6'b100001, 2'b10, 16'h5A00);
    drive(1, 1'b1, 1'b0, 6'b100101, 2'b10, 16'h0);
    #1;
    got = b_rdata;
    chk("R9 read sees old data", got, mbm[0][1]);
    @(posedge clk);
    #1;
    model_ack(1, 6'b100101, 2'b10);
    model_wr(0, 6'b100001, 2'b10, 16'h5A00);
    drive(0, 1'b0, 1'b0, 6'h0, 2'b00, 16'h0);
    drive(1, 1'b0, 1'b0, 6'h0, 2'b00, 16'h0);
    chk_irq("R9 raise wins");
    rd(1, 6'b101000, 2'b11, "R9 ctrl pending");
    rd(1, 6'b100101, 2'b10, "R9 later ack clears");
  endtask

  task automatic t_b_to_a;
    wr(1, 6'b100001, 2'b11, 16'hC0DE, "R4 B raises A box1");
    rd(0, 6'b101000, 2'b11, "R5 A ctrl");
    rd(0, 6'b100101, 2'b11, "R6 A acks box1");
    rd(0, 6'b101000, 2'b11, "R6 A ctrl after ack");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 4; k++) mbm[p][k] = 16'h0;
      mk[p] = 4'hF; cs[p] = 4'h0; st[p] = 4'h0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_lanes();
    t_peer_view();
    t_irq_set();
    t_ack();
    t_mask();
    t_ctrl_fields();
    t_reserved();
    t_collide();
    t_b_to_a();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule